// File: doc/BRIEF.md
# Interrupt Translation Command Queue Engine

This block is the consumer side of a circular command ring kept in memory. Software writes 32-byte translation commands into the ring and then moves a producer offset register forward. The engine sees that the producer and consumer offsets differ and fetches the next command as four 64-bit words over a single-beat memory read port. It splits the 256-bit command into its fields and offers the result on a valid/ready output. The consumer offset moves forward only after the command has been taken, so software can poll it to learn how far the ring has been drained.

The ring size is a parameter: QUEUE_BYTES bytes, holding QUEUE_BYTES/32 slots. Both offsets are byte offsets that are multiples of 32. They wrap from the last slot back to slot 0. A producer offset that is misaligned or that lies beyond the ring is refused and latches a sticky error. Commands with an unknown opcode are dropped without being offered downstream.

Top module: `itq_cmd_engine`

## Requirements
- R1: After reset, `rd_off` and `wr_off` are 0, `q_empty` is 1, `q_full` is 0, and `ptr_err`, `cmd_valid`, `bad_op` and `mem_req` are all 0.
- R2: Each command is fetched as four reads, one at a time. Their byte addresses are slot*32, +8, +16 and +24, in ascending order. A new read is requested only after the data of the previous read has returned.
- R3: With w0, w1 and w2 the 64-bit little-endian words at command offsets 0, 8 and 16, the fields are:
  - opcode = w0[7:0] and device ID = w0[63:32];
  - event ID = w1[31:0], physical ID = w1[63:32], size = w1[4:0], and log2 of the entry count = size+1;
  - table address = w2[47:0] with bits [7:0] cleared, and target = w2[47:0] with bits [15:0] cleared;
  - collection = w2[15:0] and valid flag = w2[63].
- R4: A presented command keeps `cmd_valid` and all fields stable until `cmd_ready`. `rd_off` holds the presented slot until acceptance, and moves to the next slot (+32) in the cycle after the accepting clock edge.
- R5: Advancing from the last slot (QUEUE_BYTES-32) sets `rd_off` to 0.
- R6: `q_empty` is 1 exactly when `rd_off` equals `wr_off`. While empty, the engine issues no memory reads.
- R7: `q_full` is 1 exactly when (write slot + 1) modulo the slot count equals the read slot.
- R8: The accepted opcodes are:
  - 0x01, 0x03, 0x05, 0x08, 0x09;
  - 0x0A, 0x0C, 0x0D, 0x0F.
  Any other opcode raises `bad_op` for one cycle and never raises `cmd_valid`. The slot is then skipped, and `rd_off` advances in the next cycle.
- R9: A write to `wr_off` whose value has bits [4:0] nonzero, or whose value is at least QUEUE_BYTES, leaves `wr_off` unchanged and sets `ptr_err`. `ptr_err` stays set until reset, and while it is set no new command fetch starts.
- R10: A write of an aligned in-range value updates `wr_off` on the next clock edge, whether or not `ptr_err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_off_we | input | 1 | Write strobe for the producer offset |
| wr_off_wdata | input | 32 | New producer byte offset |
| wr_off | output | 32 | Current producer byte offset |
| rd_off | output | 32 | Current consumer byte offset |
| q_empty | output | 1 | Offsets are equal |
| q_full | output | 1 | Ring holds slot count minus one commands |
| ptr_err | output | 1 | Sticky bad-offset error |
| mem_req | output | 1 | Read request, held until granted |
| mem_addr | output | log2(QUEUE_BYTES) | Byte address within the ring of the requested word |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data word |
| cmd_valid | output | 1 | Decoded command offered |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_op | output | 8 | Opcode |
| cmd_devid | output | 32 | Device ID |
| cmd_event | output | 32 | Event ID |
| cmd_pintid | output | 32 | Physical interrupt ID |
| cmd_size | output | 5 | Raw size field |
| cmd_ite_log2 | output | 6 | log2 of entry count (size+1) |
| cmd_table_addr | output | 48 | 256-byte-aligned table address |
| cmd_target | output | 48 | 64 KiB-aligned target address |
| cmd_coll | output | 16 | Collection ID |
| cmd_vflag | output | 1 | Valid flag |
| bad_op | output | 1 | One-cycle pulse on a skipped unknown opcode |

## Verification
The assertions assume a well-behaved read port: `mem_rvalid` comes at least one cycle after the grant of its request, never arrives unrequested, and a grant only occurs while `mem_req` is high. The bench's memory model follows these rules by construction. It grants with a varying pattern and returns data after one or two cycles. The assertions also assume that software does not move `wr_off` while a command is in flight. The bench writes the ring and the producer offset only when the engine is drained. This holds over several wraps of an eight-slot ring, except in the error scenario, where fetching is stopped.

// File: rtl/itq_pkg.sv
package itq_pkg;

   localparam int ITQ_WORD_W    = 64;
   localparam int ITQ_CMD_WORDS = 4;
   localparam int ITQ_CMD_BYTES = 32;

   typedef enum logic [7:0] {
      OP_MOVE     = 8'h01,
      OP_INT      = 8'h03,
      OP_SYNC     = 8'h05,
      OP_MAPDEV   = 8'h08,
      OP_MAPCOL   = 8'h09,
      OP_MAPVIRT  = 8'h0A,
      OP_INV      = 8'h0C,
      OP_INVALL   = 8'h0D,
      OP_DISCARD  = 8'h0F
   } itq_op_e;

   typedef struct packed {
      logic [7:0]  op;
      logic [31:0] devid;
      logic [31:0] event_id;
      logic [31:0] pintid;
      logic [4:0]  size;
      logic [5:0]  ite_log2;
      logic [47:0] table_addr;
      logic [47:0] target;
      logic [15:0] coll;
      logic        vflag;
   } itq_cmd_t;

   function automatic logic itq_op_known(input logic [7:0] op);
      logic k;
      case (op)
         OP_MOVE, OP_INT, OP_SYNC, OP_MAPDEV, OP_MAPCOL,
         OP_MAPVIRT, OP_INV, OP_INVALL, OP_DISCARD: k = 1'b1;
         default:                                   k = 1'b0;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/itq_ptr_regs.sv
module itq_ptr_regs #(
   parameter int SLOTS  = 2048,
   parameter int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_we,
   input  logic [31:0]       wr_wdata,
   input  logic              adv,
   output logic [SLOT_W-1:0] wr_slot,
   output logic [SLOT_W-1:0] rd_slot,
   output logic              empty,
   output logic              full,
   output logic              ptr_err
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
   localparam logic [26:0]       SLOTS_HI  = 27'(SLOTS);

   if (SLOTS < 2 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("itq_ptr_regs: SLOTS must be a power of two of at least 2");
   end

   function automatic logic [SLOT_W-1:0] step(input logic [SLOT_W-1:0] s);
      return (s == LAST_SLOT) ? '0 : s + SLOT_W'(1);
   endfunction

   logic wr_aligned;
   logic wr_in_range;
   logic wr_ok;

   assign wr_aligned  = (wr_wdata[4:0] == 5'd0);
   assign wr_in_range = (wr_wdata[31:5] < SLOTS_HI);
   assign wr_ok       = wr_aligned && wr_in_range;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_slot <= '0;
         ptr_err <= 1'b0;
      end else if (wr_we) begin
         if (wr_ok) wr_slot <= wr_wdata[SLOT_W+4:5];
         else       ptr_err <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   rd_slot <= '0;
      else if (adv) rd_slot <= step(rd_slot);
   end

   assign empty = (rd_slot == wr_slot);
   assign full  = (step(wr_slot) == rd_slot);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_err |=> ptr_err);

   assert_misaligned_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_we && wr_wdata[4:0] != 5'd0) |=> (ptr_err && $stable(wr_slot)));

   assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(rd_slot));

   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && rd_slot == LAST_SLOT) |=> (rd_slot == '0));

endmodule

// File: rtl/itq_decode.sv
module itq_decode
   import itq_pkg::*;
#(
   parameter int WORD_W = ITQ_WORD_W,
   parameter int NWORDS = ITQ_CMD_WORDS
) (
   input  logic [NWORDS*WORD_W-1:0] words,
   output itq_cmd_t                 cmd,
   output logic                     known
);

   if (WORD_W != 64 || NWORDS != 4) begin : g_bad_shape
      $error("itq_decode: command layout needs four 64-bit words");
   end

   logic [WORD_W-1:0] w0, w1, w2, w3;
   assign w0 = words[0*WORD_W +: WORD_W];
   assign w1 = words[1*WORD_W +: WORD_W];
   assign w2 = words[2*WORD_W +: WORD_W];
   assign w3 = words[3*WORD_W +: WORD_W];

   always_comb begin
      cmd.op         = w0[7:0];
      cmd.devid      = w0[63:32];
      cmd.event_id   = w1[31:0];
      cmd.pintid     = w1[63:32];
      cmd.size       = w1[4:0];
      cmd.ite_log2   = {1'b0, w1[4:0]} + 6'd1;
      cmd.table_addr = {w2[47:8], 8'h00};
      cmd.target     = {w2[47:16], 16'h0000};
      cmd.coll       = w2[15:0];
      cmd.vflag      = w2[63];
      known          = itq_op_known(w0[7:0]);
   end

   logic unused_bits;
   assign unused_bits = ^{w0[31:8], w2[62:48], w3};

endmodule

// File: rtl/itq_fetch.sv
module itq_fetch #(
   parameter int SLOT_W = 11,
   parameter int WORD_W = 64,
   parameter int NWORDS = 4,
   parameter int IDX_W  = $clog2(NWORDS),
   parameter int BSH    = $clog2(WORD_W / 8),
   parameter int ADDR_W = SLOT_W + IDX_W + BSH
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     empty,
   input  logic                     halt,
   input  logic [SLOT_W-1:0]        rd_slot,
   input  logic                     known,
   input  logic                     cmd_ready,
   input  logic                     mem_gnt,
   input  logic                     mem_rvalid,
   input  logic [WORD_W-1:0]        mem_rdata,
   output logic                     mem_req,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [NWORDS*WORD_W-1:0] words,
   output logic                     cmd_valid,
   output logic                     bad_op,
   output logic                     adv
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

   if ((1 << IDX_W) != NWORDS || NWORDS < 2) begin : g_bad_nwords
      $error("itq_fetch: NWORDS must be a power of two of at least 2");
   end

   typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_PRES} fst_e;

   fst_e             st;
   logic [IDX_W-1:0] idx;
   logic             beat_done;

   assign beat_done = (st == F_WAIT) && mem_rvalid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= F_IDLE;
         idx <= '0;
      end else begin
         case (st)
            F_IDLE: if (!empty && !halt) begin
               st  <= F_REQ;
               idx <= '0;
            end
            F_REQ:  if (mem_gnt) st <= F_WAIT;
            F_WAIT: if (mem_rvalid) begin
               if (idx == LAST_IDX) st <= F_PRES;
               else begin
                  st  <= F_REQ;
                  idx <= idx + IDX_W'(1);
               end
            end
            F_PRES: if (adv) st <= F_IDLE;
            default: st <= F_IDLE;
         endcase
      end
   end

   logic [WORD_W-1:0] wbuf [NWORDS];

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)
            wbuf[w] <= '0;
         else if (beat_done && idx == IDX_W'(w))
            wbuf[w] <= mem_rdata;
      end
      assign words[w*WORD_W +: WORD_W] = wbuf[w];
   end

   assign mem_req   = (st == F_REQ);
   assign mem_addr  = {rd_slot, idx, {BSH{1'b0}}};
   assign cmd_valid = (st == F_PRES) && known;
   assign bad_op    = (st == F_PRES) && !known;
   assign adv       = bad_op || (cmd_valid && cmd_ready);

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(words)));

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_done && idx != LAST_IDX) |=>
         (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(WORD_W / 8)));

   assert_quiet_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == F_IDLE && (empty || halt)) |=> !mem_req);

   assert_skip_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op |=> (!bad_op && !cmd_valid));

endmodule

// File: rtl/itq_cmd_engine.sv
module itq_cmd_engine
   import itq_pkg::*;
#(
   parameter int QUEUE_BYTES = 65536,
   parameter int ADDR_W      = $clog2(QUEUE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_off_we,
   input  logic [31:0]       wr_off_wdata,
   output logic [31:0]       wr_off,
   output logic [31:0]       rd_off,
   output logic              q_empty,
   output logic              q_full,
   output logic              ptr_err,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [63:0]       mem_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [7:0]        cmd_op,
   output logic [31:0]       cmd_devid,
   output logic [31:0]       cmd_event,
   output logic [31:0]       cmd_pintid,
   output logic [4:0]        cmd_size,
   output logic [5:0]        cmd_ite_log2,
   output logic [47:0]       cmd_table_addr,
   output logic [47:0]       cmd_target,
   output logic [15:0]       cmd_coll,
   output logic              cmd_vflag,
   output logic              bad_op
);

   localparam int SLOTS  = QUEUE_BYTES / ITQ_CMD_BYTES;
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int OFF_SH = $clog2(ITQ_CMD_BYTES);

   if (QUEUE_BYTES < 64 || QUEUE_BYTES > 32'h4000_0000 ||
       (QUEUE_BYTES & (QUEUE_BYTES - 1)) != 0) begin : g_bad_size
      $error("itq_cmd_engine: QUEUE_BYTES must be a power of two from 64 up");
   end
   if (ADDR_W != SLOT_W + OFF_SH) begin : g_bad_addr
      $error("itq_cmd_engine: ADDR_W must stay at its derived value");
   end

   logic [SLOT_W-1:0]                       wr_slot, rd_slot;
   logic                                    adv, known;
   logic [ITQ_CMD_WORDS*ITQ_WORD_W-1:0]     words;
   itq_cmd_t                                cmd;

   itq_ptr_regs #(.SLOTS(SLOTS)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_we    (wr_off_we),
      .wr_wdata (wr_off_wdata),
      .adv      (adv),
      .wr_slot  (wr_slot),
      .rd_slot  (rd_slot),
      .empty    (q_empty),
      .full     (q_full),
      .ptr_err  (ptr_err)
   );

   itq_fetch #(
      .SLOT_W (SLOT_W),
      .WORD_W (ITQ_WORD_W),
      .NWORDS (ITQ_CMD_WORDS)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .empty      (q_empty),
      .halt       (ptr_err),
      .rd_slot    (rd_slot),
      .known      (known),
      .cmd_ready  (cmd_ready),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .words      (words),
      .cmd_valid  (cmd_valid),
      .bad_op     (bad_op),
      .adv        (adv)
   );

   itq_decode #(
      .WORD_W (ITQ_WORD_W),
      .NWORDS (ITQ_CMD_WORDS)
   ) u_dec (
      .words (words),
      .cmd   (cmd),
      .known (known)
   );

   assign wr_off = {{(32-SLOT_W-OFF_SH){1'b0}}, wr_slot, {OFF_SH{1'b0}}};
   assign rd_off = {{(32-SLOT_W-OFF_SH){1'b0}}, rd_slot, {OFF_SH{1'b0}}};

   assign cmd_op         = cmd.op;
   assign cmd_devid      = cmd.devid;
   assign cmd_event      = cmd.event_id;
   assign cmd_pintid     = cmd.pintid;
   assign cmd_size       = cmd.size;
   assign cmd_ite_log2   = cmd.ite_log2;
   assign cmd_table_addr = cmd.table_addr;
   assign cmd_target     = cmd.target;
   assign cmd_coll       = cmd.coll;
   assign cmd_vflag      = cmd.vflag;

endmodule

// File: tb/itq_cmd_engine_test.sv
module itq_cmd_engine_test;

   localparam int CLK_PERIOD = 10;
   localparam int QB         = 256;
   localparam int SLOTS      = QB / 32;
   localparam int NW         = SLOTS * 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_off_we = 1'b0;
   logic [31:0] wr_off_wdata = '0;
   logic [31:0] wr_off, rd_off;
   logic        q_empty, q_full, ptr_err, mem_req;
   logic [7:0]  mem_addr;
   logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        cmd_valid, bad_op;
   logic        cmd_ready = 1'b0;
   logic [7:0]  cmd_op;
   logic [31:0] cmd_devid, cmd_event, cmd_pintid;
   logic [4:0]  cmd_size;
   logic [5:0]  cmd_ite_log2;
   logic [47:0] cmd_table_addr, cmd_target;
   logic [15:0] cmd_coll;
   logic        cmd_vflag;

   itq_cmd_engine #(.QUEUE_BYTES(QB)) uut (
      .clk(clk), .rst_n(rst_n), .wr_off_we(wr_off_we), .wr_off_wdata(wr_off_wdata),
      .wr_off(wr_off), .rd_off(rd_off), .q_empty(q_empty), .q_full(q_full),
      .ptr_err(ptr_err), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_devid(cmd_devid),
      .cmd_event(cmd_event), .cmd_pintid(cmd_pintid), .cmd_size(cmd_size),
      .cmd_ite_log2(cmd_ite_log2), .cmd_table_addr(cmd_table_addr),
      .cmd_target(cmd_target), .cmd_coll(cmd_coll), .cmd_vflag(cmd_vflag),
      .bad_op(bad_op)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int nchk = 0;
   int nerr = 0;

   logic [63:0] mem [NW];
   int          alog [512];
   int          alog_n = 0;
   int          pend_cnt = 0;
   int          gcnt = 0;
   logic [7:0]  paddr = '0;

   // memory model: grants with a varying pattern, data 1 or 2 cycles after grant
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_gnt    = 1'b0;
         mem_rvalid = 1'b0;
         pend_cnt   = 0;
         alog_n     = 0;
      end else begin
         mem_rvalid = 1'b0;
         if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem[paddr >> 3];
            end
         end
         mem_gnt = 1'b0;
         if (mem_req && pend_cnt == 0 && !mem_rvalid && (gcnt % 3 != 2)) begin
            mem_gnt = 1'b1;
            paddr   = mem_addr;
            if (alog_n < 512) alog[alog_n] = int'(mem_addr);
            alog_n++;
            pend_cnt = 1 + (gcnt % 2);
         end
         if (mem_req) gcnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   function automatic logic [63:0] mix(input int k, input int j);
      logic [63:0] x;
      x = 64'(k * 4 + j + 1) * 64'h9E37_79B9_7F4A_7C15;
      return x ^ (x >> 29);
   endfunction

   task automatic load(input int slot, input logic [7:0] op, input int k);
      for (int j = 0; j < 4; j++) mem[slot*4 + j] = mix(k, j);
      mem[slot*4][7:0] = op;
   endtask

   task automatic write_off(input logic [31:0] v);
      @(negedge clk);
      wr_off_we    = 1'b1;
      wr_off_wdata = v;
      @(negedge clk);
      wr_off_we    = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   int ncmd = 0;

   task automatic consume(input int slot, input bit known, input int hold);
      int waited = 0;
      int nxt;
      logic [63:0] w0, w1, w2;
      logic [255:0] act_f, exp_f;
      while (!(cmd_valid || bad_op) && waited < 400) begin
         @(negedge clk);
         waited++;
      end
      w0 = mem[slot*4];
      w1 = mem[slot*4 + 1];
      w2 = mem[slot*4 + 2];
      nxt = (slot + 1) % SLOTS;
      if (known) begin
         chk(cmd_valid == 1'b1 && bad_op == 1'b0, "R8", "known opcode offered",
             {cmd_valid, bad_op}, 2'b10);
         chk(cmd_op == w0[7:0], "R3", "opcode", cmd_op, w0[7:0]);
         act_f = {cmd_devid, cmd_event, cmd_pintid, cmd_size, cmd_ite_log2,
                  cmd_table_addr, cmd_target, cmd_coll, cmd_vflag};
         exp_f = {w0[63:32], w1[31:0], w1[63:32], w1[4:0], 6'(w1[4:0]) + 6'd1,
                  w2[47:0] & ~48'hFF, w2[47:0] & ~48'hFFFF, w2[15:0], w2[63]};
         chk(act_f == exp_f, "R3", "decoded fields", act_f, exp_f);
         chk(rd_off == 32'(slot * 32), "R4", "rd_off while presented", rd_off, slot * 32);
         for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_op == w0[7:0] && rd_off == 32'(slot * 32) &&
                {cmd_devid, cmd_coll} == {w0[63:32], w2[15:0]},
                "R4", "hold without ready", {cmd_valid, rd_off}, {1'b1, 32'(slot * 32)});
         end
         cmd_ready = 1'b1;
         @(negedge clk);
         cmd_ready = 1'b0;
      end else begin
         chk(bad_op == 1'b1 && cmd_valid == 1'b0, "R8", "unknown opcode skipped",
             {bad_op, cmd_valid}, 2'b10);
         @(negedge clk);
         chk(bad_op == 1'b0, "R8", "bad_op single cycle", bad_op, 1'b0);
      end
      if (slot == SLOTS - 1)
         chk(rd_off == 32'(nxt * 32), "R5", "wrap to slot 0", rd_off, nxt * 32);
      else
         chk(rd_off == 32'(nxt * 32), "R4", "advance after accept", rd_off, nxt * 32);
      for (int j = 0; j < 4; j++)
         chk(alog[4*ncmd + j] == slot * 32 + 8 * j, "R2", "fetch address order",
             alog[4*ncmd + j], slot * 32 + 8 * j);
      ncmd++;
   endtask

   logic [7:0] kn [9];
   logic [7:0] unk [5];
   bit         kb [SLOTS];

   initial begin
      int k  = 0;
      int wb = 0;
      int rb = 0;
      kn  = '{8'h01, 8'h03, 8'h05, 8'h08, 8'h09, 8'h0A, 8'h0C, 8'h0D, 8'h0F};
      unk = '{8'h00, 8'h02, 8'h0B, 8'hFF, 8'h10};
      for (int i = 0; i < NW; i++) mem[i] = '0;

      do_reset();
      chk(rd_off == 0 && wr_off == 0, "R1", "offsets after reset", {wr_off, rd_off}, 0);
      chk(q_empty == 1'b1 && q_full == 1'b0, "R1", "empty/full after reset",
          {q_empty, q_full}, 2'b10);
      chk({ptr_err, cmd_valid, bad_op, mem_req} == 4'b0, "R1", "flags after reset",
          {ptr_err, cmd_valid, bad_op, mem_req}, 0);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(mem_req == 1'b0, "R6", "no read while empty", mem_req, 0);
      end

      for (int r = 0; r < 5; r++) begin
         int cnt = (r == 0) ? 7 : 3 + r;
         for (int i = 0; i < cnt; i++) begin
            bit is_known = (k % 7 != 5);
            load(wb, is_known ? kn[k % 9] : unk[(k / 7) % 5], k);
            kb[wb] = is_known;
            k++;
            wb = (wb + 1) % SLOTS;
         end
         write_off(32'(wb * 32));
         chk(wr_off == 32'(wb * 32), "R10", "wr_off update", wr_off, wb * 32);
         chk(q_full == (((wb + 1) % SLOTS) == rb), "R7", "full flag",
             q_full, (((wb + 1) % SLOTS) == rb));
         chk(q_empty == 1'b0, "R6", "not empty with work", q_empty, 0);
         for (int i = 0; i < cnt; i++) begin
            consume(rb, kb[rb], (i % 3) + ((r == 0 && i == 0) ? 6 : 0));
            rb = (rb + 1) % SLOTS;
         end
         chk(q_empty == 1'b1, "R6", "empty after drain", q_empty, 1);
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(mem_req == 1'b0 && cmd_valid == 1'b0, "R6", "idle when drained",
                {mem_req, cmd_valid}, 0);
         end
      end

      // misaligned producer offset
      write_off(32'(wb * 32 + 4));
      chk(ptr_err == 1'b1, "R9", "misaligned sets error", ptr_err, 1);
      chk(wr_off == 32'(wb * 32), "R9", "misaligned write ignored", wr_off, wb * 32);
      load(wb, 8'h03, 99);
      write_off(32'(((wb + 1) % SLOTS) * 32));
      chk(wr_off == 32'(((wb + 1) % SLOTS) * 32), "R10", "valid write during error",
          wr_off, ((wb + 1) % SLOTS) * 32);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         chk(mem_req == 1'b0 && cmd_valid == 1'b0 && rd_off == 32'(rb * 32) && ptr_err,
             "R9", "fetch halted", {ptr_err, mem_req, rd_off}, {1'b1, 1'b0, 32'(rb * 32)});
      end

      // reset clears, then out-of-range offset
      do_reset();
      chk(ptr_err == 1'b0 && rd_off == 0 && wr_off == 0, "R1", "reset clears error",
          {ptr_err, rd_off, wr_off}, 0);
      write_off(32'(QB));
      chk(ptr_err == 1'b1 && wr_off == 0, "R9", "out-of-range offset",
          {ptr_err, wr_off}, {1'b1, 32'h0});
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(mem_req == 1'b0, "R9", "no fetch after range error", mem_req, 0);
      end

      summary();
      $finish;
   end

endmodule